// File: doc/BRIEF.md
# Byte-wide SPI transceiver with run-time master/slave role

This block moves one byte at a time over a four-wire serial bus (clock, two data lines and an active-low select). A CPU sets it up through three byte-wide registers: a control register chooses the role (bus master or bus slave), clock idle level, sampling phase and master bit rate; a data register holds the byte; a status register reports completion, write collision and mode fault. One 8-bit shift register serves both directions, so the received byte replaces the sent byte in place. Bits travel most significant first.

As master, a write to the data register while idle starts a transfer. The block produces the serial clock from the system clock and samples the slave's data line directly. As slave, the serial clock, select and incoming data pass through two-stage synchronizers, and edges are found in the system clock domain. An interrupt line follows the completion and fault flags when enabled.

The register port is a plain single-cycle strobe interface. A write is always accepted in the cycle its strobe is high, and a read returns data combinationally in the same cycle. There is no stream handshake and no back-pressure. A write that arrives at a bad time is flagged, not stalled.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the control register (address 0) and status register (address 1) read 0, irq is 0 and all three output enables are 0.
- R2: In master mode a data write (address 2) while idle sends that byte MSB first on mosi_o. After 16 clock edges the data register reads the 8 bits sampled from miso_i, MSB first.
- R3: Control bits [1:0] = r select a master SCK half-period of 2<<r system clocks (divide by 4, 8, 16, 32). The first edge follows the starting write by one half-period.
- R4: Control bit 3 is the idle SCK level, and sck_o rests there before and after a master transfer. Control bit 2 = 0 samples data on leading edges. Bit 2 = 1 samples on trailing edges, and the first bit is valid before the first edge in both cases.
- R5: Status bit 7 (done) is set when a byte completes. irq equals control bit 6 AND (done OR mode fault).
- R6: A data write during a transfer sets status bit 6 (collision) and changes neither the byte being sent nor the byte received.
- R7: If ss_i is low while the block is an enabled master (control bit 5 = enable, bit 4 = master), status bit 4 (mode fault) is set. Control bit 4 clears, sck_oe and mosi_oe drop, and any transfer stops.
- R8: A status read followed later by a data-register access clears all three flags. A flag being set in the same cycle as that clearing access stays set.
- R9: As an enabled slave the block receives a byte from mosi_i correctly with SCK toggling every system clock (half the system clock rate).
- R10: As a slave the block drives its byte MSB first on miso_o. miso_oe is high only while enabled as slave with ss_i low.
- R11: Raising ss_i during a slave transfer drops the partial byte. The next full byte under select is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Drive enable for sck_o |
| mosi_i | input | 1 | Master-out data in (slave) |
| mosi_o | output | 1 | Master-out data (master) |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Slave-out data in (master) |
| miso_o | output | 1 | Slave-out data (slave) |
| miso_oe | output | 1 | Drive enable for miso_o |
| ss_i | input | 1 | Active-low select / fault sense |

## Verification
Two things can land on the same clock edge: a transfer completing and setting done, and the data-register access that clears the flags after a status read. The bench runs slave transfers and sweeps the cycle of the status read and the following data read across the completion window, one cycle at a time. For each offset it records irq just before the clearing access. If irq was already high, the access came after completion and the flag must end cleared. Otherwise the completion came at or after the access and done must end set.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // control register layout, bit 6 down to bit 0
  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [N];

  for (genvar s = 0; s < N; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[N-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  localparam int CW = (1 << RW) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;

  assign half = CW'(2) << rate;
  assign tick = run && (cnt == half - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          load,
  input  logic [DW-1:0]                 load_data,
  input  logic                          edge_ev,
  input  logic                          cpha,
  input  logic                          in_bit,
  output logic [DW-1:0]                 sh,
  output logic [$clog2(2*DW+1)-1:0]     cnt,
  output logic                          fin
);
  localparam int CW = $clog2(2*DW+1);
  localparam logic [CW-1:0] LAST = CW'(2*DW);

  logic pend, sbit;

  assign fin = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; pend <= 1'b0; sbit <= 1'b0;
    end else begin
      if (load) sh <= load_data;
      if (clr) begin
        cnt <= '0; pend <= 1'b0;
      end else if (fin) begin
        if (pend) sh <= {sh[DW-2:0], sbit};
        if (edge_ev) begin
          cnt  <= CW'(1);
          pend <= !cpha;
          if (!cpha) sbit <= in_bit;
        end else begin
          cnt <= '0; pend <= 1'b0;
        end
      end else if (edge_ev) begin
        cnt <= cnt + CW'(1);
        if (cnt[0] == cpha) begin
          sbit <= in_bit; pend <= 1'b1;
        end else if (pend) begin
          sh <= {sh[DW-2:0], sbit}; pend <= 1'b0;
        end
      end
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> cnt <= CW'(1));
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_pkg::*;
#(
  parameter int DW     = 8,
  parameter int RW     = 2,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_i
);
  localparam int CW = $clog2(2*DW+1);

  ctrl_t ctrl;
  logic done_f, wcol_f, modf_f, arm, run, phase, sck_q;
  logic sck_s, ss_s, mosi_s, tick, fin;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;

  spi_sync #(.W(3), .N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_i, ss_i, mosi_i}), .q({sck_s, ss_s, mosi_s}));

  spi_clkgen #(.RW(RW)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(ctrl.rate), .tick(tick));

  logic m_act, s_act, sel, s_edge, m_edge, edge_ev, busy;
  logic wr_data, rd_data, rd_stat, wr_ctrl, start, load, modf_trip, clr, done_set, clear_acc;

  assign m_act     = ctrl.enable & ctrl.master;
  assign s_act     = ctrl.enable & !ctrl.master;
  assign sel       = s_act & !ss_s;
  assign s_edge    = sel & (sck_s ^ sck_q);
  assign m_edge    = tick & run & !fin;
  assign edge_ev   = m_act ? m_edge : s_edge;
  assign busy      = run | (sel & (cnt != '0));
  assign wr_data   = bus_wr && bus_addr == ADDR_DATA;
  assign rd_data   = bus_rd && bus_addr == ADDR_DATA;
  assign rd_stat   = bus_rd && bus_addr == ADDR_STAT;
  assign wr_ctrl   = bus_wr && bus_addr == ADDR_CTRL;
  assign modf_trip = m_act & !ss_s;
  assign start     = wr_data & m_act & !run & !modf_trip;
  assign load      = wr_data & !busy;
  assign clr       = start | modf_trip | (!m_act & !sel);
  assign done_set  = fin & !clr;
  assign clear_acc = arm & (wr_data | rd_data);

  spi_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_data(bus_wdata),
    .edge_ev(edge_ev), .cpha(ctrl.cpha), .in_bit(m_act ? miso_i : mosi_s),
    .sh(sh), .cnt(cnt), .fin(fin));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; done_f <= 1'b0; wcol_f <= 1'b0; modf_f <= 1'b0;
      arm <= 1'b0; run <= 1'b0; phase <= 1'b0; sck_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[6:0]);
      if (modf_trip) ctrl.master <= 1'b0;

      if (modf_trip)      run <= 1'b0;
      else if (start)     run <= 1'b1;
      else if (run & fin) run <= 1'b0;

      if (!run)        phase <= 1'b0;
      else if (m_edge) phase <= ~phase;

      if (rd_stat)        arm <= 1'b1;
      else if (clear_acc) arm <= 1'b0;

      done_f <= done_set             | (done_f & !clear_acc);
      wcol_f <= (wr_data & busy)     | (wcol_f & !clear_acc);
      modf_f <= modf_trip            | (modf_f & !clear_acc);
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = DW'({1'b0, ctrl});
      ADDR_STAT: bus_rdata = DW'({done_f, wcol_f, 1'b0, modf_f, 4'b0});
      ADDR_DATA: bus_rdata = sh;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq     = ctrl.irq_en & (done_f | modf_f);
  assign sck_o   = ctrl.cpol ^ phase;
  assign sck_oe  = m_act;
  assign mosi_o  = sh[DW-1];
  assign mosi_oe = m_act;
  assign miso_o  = sh[DW-1];
  assign miso_oe = sel;

  // R7
  modf_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modf_trip |=> (modf_f && !sck_oe && !mosi_oe && !run));
  // R6
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol_f);
  // R5
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done_f);
  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act && !run) |-> sck_o == ctrl.cpol);
  // R10
  oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_oe && miso_oe));
endmodule

// File: tb/spi_xcvr_bench.sv
module spi_xcvr_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
  logic sck_i = 0, mosi_i = 0, ss_i = 1;

  spi_xcvr u_spi_xcvr (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_i(ss_i));

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;

  // bench-side slave model used while the design is master
  logic bs_en = 0, cur_cpha = 0;
  logic [7:0] bs_tx = 0, bs_rx;
  logic [2:0] bs_idx;
  logic bs_prev;
  int bs_e, bs_t0, bs_t1;
  assign miso_i = bs_tx[bs_idx];

  always @(negedge clk) begin
    cyc++;
    if (!bs_en) begin
      bs_e = 0; bs_idx = 3'd7; bs_rx = 0; bs_prev = sck_o;
    end else if (sck_oe && sck_o != bs_prev) begin
      bs_prev = sck_o;
      if (bs_e == 0) bs_t0 = cyc;
      if (bs_e == 1) bs_t1 = cyc;
      if (!cur_cpha) begin
        if (bs_e % 2 == 0) bs_rx = {bs_rx[6:0], mosi_o};
        else if (bs_e < 15) bs_idx = 3'(6 - bs_e / 2);
      end else begin
        if (bs_e % 2 == 0) bs_idx = 3'(7 - bs_e / 2);
        else bs_rx = {bs_rx[6:0], mosi_o};
      end
      bs_e++;
    end
  end

  function automatic int half_of(input int rate);
    return 2 << rate;
  endfunction

  function automatic logic [7:0] stat_of(input bit d, input bit w, input bit m);
    return {d, w, 1'b0, m, 4'b0};
  endfunction

  function automatic logic [7:0] ctrl_of(input bit ie, input bit en, input bit mst,
                                         input bit cpol, input bit cpha, input int rate);
    return {1'b0, ie, en, mst, cpol, cpha, 2'(rate)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rd_pre(output logic pre);
    @(negedge clk); bus_rd = 1; bus_addr = 2'd2; pre = irq;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic clear_flags();
    logic [7:0] v;
    rd(2'd1, v); rd(2'd2, v);
  endtask

  // bench acts as master while the design is slave
  logic saw_oe;
  task automatic drive(input logic [7:0] tx, input int half, input bit cpol,
                       input bit cpha, input int nbits, output logic [7:0] rx);
    rx = 0; saw_oe = 0;
    @(negedge clk); ss_i = 0; mosi_i = tx[7];
    repeat (half) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (cpha) mosi_i = tx[7-i];
      if (!cpha) rx = {rx[6:0], miso_o};
      sck_i = ~cpol;
      repeat (half) @(negedge clk);
      if (i == 0) saw_oe = miso_oe;
      if (cpha) rx = {rx[6:0], miso_o};
      sck_i = cpol;
      if (!cpha && i < 7) mosi_i = tx[6-i];
      repeat (half) @(negedge clk);
    end
    repeat (8) @(negedge clk); ss_i = 1; repeat (4) @(negedge clk);
  endtask

  task automatic mtest(input int rate, input bit cpol, input bit cpha, input bit ie,
                       input logic [7:0] tx, input logic [7:0] stx, input bit coll);
    logic [7:0] v;
    int h = half_of(rate);
    cur_cpha = cpha;
    wr(2'd0, ctrl_of(ie, 1, 1, cpol, cpha, rate));
    repeat (3) @(negedge clk);
    chk("R4 idle sck level", sck_o, cpol);
    bs_tx = stx; bs_en = 1;
    @(negedge clk);
    wr(2'd2, tx);
    if (coll) begin repeat (h) @(negedge clk); wr(2'd2, ~tx); end
    repeat (16 * h + 6) @(negedge clk);
    rd(2'd1, v);
    chk(coll ? "R6 collision flag" : "R5 done flag", v, stat_of(1, coll, 0));
    chk("R5 irq follows done", irq, ie);
    chk("R3 sck half period", bs_t1 - bs_t0, h);
    chk(coll ? "R6 sent byte intact" : "R2 mosi byte", bs_rx, tx);
    chk("R4 sck back at idle", sck_o, cpol);
    rd(2'd2, v);
    chk(coll ? "R6 received byte intact" : "R2 received byte", v, stx);
    rd(2'd1, v);
    chk("R8 flags cleared", v, 8'h00);
    bs_en = 0;
  endtask

  task automatic stest(input int half, input bit cpol, input bit cpha,
                       input logic [7:0] tx, input logic [7:0] pre, input bit duplex);
    logic [7:0] v, rx;
    sck_i = cpol;
    wr(2'd0, ctrl_of(1, 1, 0, cpol, cpha, 0));
    repeat (4) @(negedge clk);
    wr(2'd2, pre);
    chk("R10 miso undriven while unselected", miso_oe, 1'b0);
    drive(tx, half, cpol, cpha, 8, rx);
    rd(2'd1, v);
    chk("R5 slave done flag", v, stat_of(1, 0, 0));
    rd(2'd2, v);
    chk(half == 1 ? "R9 receive at half clock rate" : "R9 slave receive", v, tx);
    if (duplex) begin
      chk("R10 slave miso byte", rx, pre);
      chk("R10 miso driven while selected", saw_oe, 1'b1);
    end
  endtask

  task automatic run_tests();
    logic [7:0] v, rx;
    logic pre;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    rd(2'd0, v); chk("R1 control reset", v, 8'h00);
    rd(2'd1, v); chk("R1 status reset", v, 8'h00);
    chk("R1 irq reset", irq, 1'b0);
    chk("R1 enables reset", {sck_oe, mosi_oe, miso_oe}, 3'b000);

    // directed: every rate and every mode
    for (int r = 0; r < 4; r++) mtest(r, r[0], r[1], 1, 8'hA5 ^ 8'(r), 8'h3C + 8'(r), 0);
    // random master transfers
    for (int k = 0; k < 6; k++) begin
      int m = $urandom % 16;
      mtest(m % 4, m[2], m[3], $urandom % 2, 8'($urandom), 8'($urandom), 0);
    end
    // collision during transfer
    mtest(1, 0, 0, 1, 8'hC3, 8'h69, 1);
    mtest(0, 1, 1, 1, 8'h1E, 8'hE1, 1);

    // mode fault while idle
    wr(2'd0, ctrl_of(1, 1, 1, 0, 0, 0));
    repeat (2) @(negedge clk);
    ss_i = 0; repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R7 fault flag", v, stat_of(0, 0, 1));
    rd(2'd0, v); chk("R7 master bit cleared", v[4], 1'b0);
    chk("R7 drivers released", {sck_oe, mosi_oe}, 2'b00);
    chk("R5 irq on fault", irq, 1'b1);
    ss_i = 1; repeat (3) @(negedge clk);
    rd(2'd2, v); rd(2'd1, v); chk("R8 fault cleared", v, 8'h00);

    // mode fault during a transfer
    wr(2'd0, ctrl_of(0, 1, 1, 0, 0, 2));
    wr(2'd2, 8'h77);
    repeat (12) @(negedge clk);
    ss_i = 0; repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R7 fault stops transfer", v, stat_of(0, 0, 1));
    ss_i = 1; repeat (3) @(negedge clk);
    clear_flags();

    // slave: directed and random modes
    stest(6, 0, 0, 8'h5B, 8'hD2, 1);
    stest(6, 1, 1, 8'h81, 8'h7E, 1);
    for (int k = 0; k < 4; k++) begin
      int m = $urandom % 4;
      stest(6, m[0], m[1], 8'($urandom), 8'($urandom), 1);
    end
    stest(1, 0, 0, 8'h96, 8'h00, 0);
    stest(1, 1, 1, 8'h4D, 8'h00, 0);

    // abort under deselect, then a full byte
    sck_i = 0;
    wr(2'd0, ctrl_of(1, 1, 0, 0, 0, 0));
    repeat (4) @(negedge clk);
    drive(8'hFF, 4, 0, 0, 3, rx);
    rd(2'd1, v); chk("R11 no done after abort", v, 8'h00);
    drive(8'h2C, 4, 0, 0, 8, rx);
    rd(2'd2, v); chk("R11 byte after abort", v, 8'h2C);
    clear_flags();

    // set versus clear in the same cycle
    for (int off = 50; off < 74; off++) begin
      clear_flags();
      fork
        drive(8'($urandom), 4, 0, 0, 8, rx);
        begin
          repeat (off) @(negedge clk);
          rd(2'd1, v);
          rd_pre(pre);
        end
      join
      chk("R8 set wins over clear", irq, !pre);
    end
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule